// File: doc/BRIEF.md
# Eight-State Table-Driven Mealy Controller

This block is a synchronous finite-state machine with eight states, named A to H. It has one serial input `x` and one output `z`. On every rising clock edge it moves to a successor chosen by the present state and `x`. The output `z` is a combinational function of the present state and the live value of `x`, so it is a Mealy machine. The transition and output rules are fixed, and no pattern or program can change them.

The block is meant to sit in a larger design as a fixed sequencing element. The present state is brought out on a 3-bit debug port so that neighbouring logic or a bench can follow the walk through the table.

Top module: `tbl_mealy8`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state after that edge is A, whatever `x` is. The reset is synchronous.
- R2: `state_dbg` shows the present state as a binary code: A=0, B=1, C=2, D=3, E=4, F=5, G=6, H=7.
- R3: In state A, x=0 keeps the state at A with z=1, and x=1 moves to E with z=0. In state B, x=0 moves to C with z=0, and x=1 moves to F with z=0.
- R4: In state C, x=0 moves to B with z=0, and x=1 moves to H with z=1. In state D, x=0 moves to E with z=0, and x=1 moves to F with z=0.
- R5: In state E, x=0 moves to D with z=0, and x=1 moves to A with z=1. In state F, x=0 moves to B with z=1, and x=1 keeps the state at F with z=1.
- R6: In state G, x=0 moves to D with z=0, and x=1 moves to H with z=1. In state H, x=0 keeps the state at H with z=1, and x=1 moves to G with z=0.
- R7: `z` follows a change of `x` within the same clock cycle, with no clock edge in between.
- R8: Changes of `x` between two rising edges have no effect on the state. Only the value `x` has at the edge decides the successor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset to state A |
| x | input | 1 | Serial data input |
| z | output | 1 | Mealy output from present state and live `x` |
| state_dbg | output | 3 | Present state code, A=0 to H=7 |

## Verification
`z` is due in the same cycle as the `x` that produces it. The bench drives `x` on the falling edge and samples `z` half a nanosecond before the next rising edge. A new state shows on `state_dbg` exactly one rising edge after the `x` value that selects it, so the bench reads it one nanosecond after that edge. The driver pushes one expected output and one expected successor per cycle into separate queues, and each monitor pops its queue at its own sampling instant. In this way each result is compared in the cycle in which it is due. Glitch steps toggle `x` twice inside one low phase. They check `z` after each toggle and expect a successor taken from the final value only.

// File: rtl/fsm8_pkg.sv
// Package: shared state type and the fixed transition/output rules.
// Assumes: eight states, 3-bit binary code, A is the reset state.
package fsm8_pkg;

    localparam int STATE_W    = 3;
    localparam int NUM_STATES = 1 << STATE_W;

    typedef enum logic [STATE_W-1:0] {
        ST_A = 3'd0,
        ST_B = 3'd1,
        ST_C = 3'd2,
        ST_D = 3'd3,
        ST_E = 3'd4,
        ST_F = 3'd5,
        ST_G = 3'd6,
        ST_H = 3'd7
    } st_t;

    // One row of the machine: successor and output for each value of x.
    typedef struct packed {
        st_t  succ_x0;
        st_t  succ_x1;
        logic out_x0;
        logic out_x1;
    } row_t;

    localparam st_t RESET_STATE = ST_A;

    // Returns the row for a given present state.
    function automatic row_t row_of(input st_t s);
        row_t r;
        case (s)
            ST_A:    r = '{succ_x0: ST_A, succ_x1: ST_E, out_x0: 1'b1, out_x1: 1'b0};
            ST_B:    r = '{succ_x0: ST_C, succ_x1: ST_F, out_x0: 1'b0, out_x1: 1'b0};
            ST_C:    r = '{succ_x0: ST_B, succ_x1: ST_H, out_x0: 1'b0, out_x1: 1'b1};
            ST_D:    r = '{succ_x0: ST_E, succ_x1: ST_F, out_x0: 1'b0, out_x1: 1'b0};
            ST_E:    r = '{succ_x0: ST_D, succ_x1: ST_A, out_x0: 1'b0, out_x1: 1'b1};
            ST_F:    r = '{succ_x0: ST_B, succ_x1: ST_F, out_x0: 1'b1, out_x1: 1'b1};
            ST_G:    r = '{succ_x0: ST_D, succ_x1: ST_H, out_x0: 1'b0, out_x1: 1'b1};
            default: r = '{succ_x0: ST_H, succ_x1: ST_G, out_x0: 1'b1, out_x1: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fsm8_next.sv
// Module: fsm8_next
// Purpose: combinational successor selection from present state and x.
// Assumes: present state is always a legal code (all eight codes are legal).
module fsm8_next
    import fsm8_pkg::*;
(
    input  st_t  cur,
    input  logic x,
    output st_t  nxt
);

    row_t row;

    // Look up the row of the present state, then pick by x.
    always_comb begin
        row = row_of(cur);
        nxt = x ? row.succ_x1 : row.succ_x0;
    end

endmodule

// File: rtl/fsm8_out.sv
// Module: fsm8_out
// Purpose: Mealy output; z depends on the present state and the live x.
// Assumes: x may change anywhere in the cycle; z follows without a clock.
module fsm8_out
    import fsm8_pkg::*;
(
    input  st_t  cur,
    input  logic x,
    output logic z
);

    logic [NUM_STATES-1:0] z_when0;
    logic [NUM_STATES-1:0] z_when1;

    // Build the two output columns, one bit per state code.
    for (genvar s = 0; s < NUM_STATES; s++) begin : g_col
        localparam row_t ROW = row_of(st_t'(s));
        assign z_when0[s] = ROW.out_x0;
        assign z_when1[s] = ROW.out_x1;
    end

    // Index the column chosen by x with the present state.
    always_comb begin
        z = x ? z_when1[cur] : z_when0[cur];
    end

endmodule

// File: rtl/fsm8_streg.sv
// Module: fsm8_streg
// Purpose: present-state register with synchronous active-low reset.
// Assumes: rst_n is synchronous to clk.
module fsm8_streg
    import fsm8_pkg::*;
#(
    parameter st_t INIT = RESET_STATE
) (
    input  logic clk,
    input  logic rst_n,
    input  st_t  d,
    output st_t  q
);

    // Capture the successor on each rising edge, or force INIT in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= INIT;
        else        q <= d;
    end

endmodule

// File: rtl/tbl_mealy8.sv
// Module: tbl_mealy8 (top)
// Purpose: eight-state Mealy machine driven by a fixed rule table.
// Assumes: single clock domain, synchronous active-low reset to state A.
module tbl_mealy8
    import fsm8_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               x,
    output logic               z,
    output logic [STATE_W-1:0] state_dbg
);

    st_t cur_st;
    st_t nxt_st;

    fsm8_next u_next (
        .cur (cur_st),
        .x   (x),
        .nxt (nxt_st)
    );

    fsm8_streg #(.INIT(RESET_STATE)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt_st),
        .q     (cur_st)
    );

    fsm8_out u_out (
        .cur (cur_st),
        .x   (x),
        .z   (z)
    );

    // Expose the present state code for observation.
    assign state_dbg = cur_st;

endmodule

// File: rtl/fsm8_chk.sv
// Module: fsm8_chk
// Purpose: temporal checks on the ports of tbl_mealy8, bound below.
// Assumes: rst_n is low at the first rising edge.
module fsm8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       x,
    input logic       z,
    input logic [2:0] st
);

    // R1
    rst_to_a_chk: assert property (@(posedge clk) !rst_n |=> st == 3'd0);

    // R3
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd0 && !x) |-> z);

    // R3
    a_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd0 && !x && $past(rst_n)) |=> (!rst_n || st == 3'd0));

    // R4
    bd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd1 || st == 3'd3) |-> !z);

    // R5
    f_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd5) |-> z);

    // R6
    h_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd7 && !x) |=> (!rst_n || st == 3'd7));

endmodule

bind tbl_mealy8 fsm8_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .x     (x),
    .z     (z),
    .st    (state_dbg)
);

// File: tb/sim_tbl_mealy8.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver pushes expected z and successor values,
// and two monitors pop and compare them at their own sampling points.
module sim_tbl_mealy8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       x = 1'b0;
    logic       z;
    logic [2:0] state_dbg;

    int n_cmp = 0;
    int n_bad = 0;

    logic  zq[$];
    string zt[$];
    logic [2:0] sq[$];
    string st[$];
    logic [2:0] ms = 3'd0;
    bit seen [16];

    tbl_mealy8 u0 (.clk(clk), .rst_n(rst_n), .x(x), .z(z), .state_dbg(state_dbg));

    always #2.5 clk = ~clk;

    // Independent model of the rules: successor.
    function automatic logic [2:0] m_next(input logic [2:0] s, input logic xv);
        case ({s, xv})
            4'b000_0: return 3'd0;  4'b000_1: return 3'd4;
            4'b001_0: return 3'd2;  4'b001_1: return 3'd5;
            4'b010_0: return 3'd1;  4'b010_1: return 3'd7;
            4'b011_0: return 3'd4;  4'b011_1: return 3'd5;
            4'b100_0: return 3'd3;  4'b100_1: return 3'd0;
            4'b101_0: return 3'd1;  4'b101_1: return 3'd5;
            4'b110_0: return 3'd3;  4'b110_1: return 3'd7;
            default:  return xv ? 3'd6 : 3'd7;
        endcase
    endfunction

    // Independent model of the rules: output.
    function automatic logic m_z(input logic [2:0] s, input logic xv);
        logic [7:0] c0 = 8'b1010_0001;
        logic [7:0] c1 = 8'b0111_0100;
        return xv ? c1[s] : c0[s];
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0, 3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one cycle with reset level r and input xv.
    task automatic step(input logic r, input logic xv);
        logic [2:0] ns;
        @(negedge clk);
        rst_n = r;
        x = xv;
        zq.push_back(m_z(ms, xv));
        zt.push_back({tag_of(ms), " z"});
        ns = r ? m_next(ms, xv) : 3'd0;
        sq.push_back(ns);
        st.push_back(r ? {tag_of(ms), "/R2 state"} : "R1 state");
        if (r) seen[{ms, xv}] = 1'b1;
        ms = ns;
    endtask

    // Driver: x toggles inside the low phase; the final value decides.
    task automatic glitch_step(input logic xv);
        logic [2:0] ns;
        @(negedge clk);
        rst_n = 1'b1;
        x = ~xv;
        #0.5;
        check(z === m_z(ms, ~xv), "R7 z first", z, m_z(ms, ~xv));
        x = xv;
        #0.5;
        check(z === m_z(ms, xv), "R7 z second", z, m_z(ms, xv));
        zq.push_back(m_z(ms, xv));
        zt.push_back({tag_of(ms), " z"});
        ns = m_next(ms, xv);
        sq.push_back(ns);
        st.push_back("R8 state");
        ms = ns;
    endtask

    // Monitor: z is due before the next rising edge.
    initial forever begin
        @(negedge clk);
        #2;
        if (zq.size() > 0) begin
            logic e;
            string t;
            e = zq.pop_front();
            t = zt.pop_front();
            check(z === e, t, z, e);
        end
    end

    // Monitor: the state is due one rising edge after its x.
    initial forever begin
        @(posedge clk);
        #1;
        if (sq.size() > 0) begin
            logic [2:0] e;
            string t;
            e = sq.pop_front();
            t = st.pop_front();
            check(state_dbg === e, t, state_dbg, e);
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        int covered;
        repeat (2) @(posedge clk);
        #1;
        check(state_dbg === 3'd0, "R1/R2 reset state", state_dbg, 0);
        ms = 3'd0;
        // A fixed walk first: A->A->E->D->F->F->B->C->H->H->G->D.
        step(1'b1, 1'b0); step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b1);
        step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
        step(1'b1, 1'b0); step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b1);
        // Random walk over every state and input pair.
        for (int i = 0; i < 3000; i++) step(1'b1, 1'($urandom));
        // Toggles inside one cycle.
        for (int i = 0; i < 60; i++) glitch_step(1'($urandom));
        // Reset at random places in the walk, with either x.
        for (int i = 0; i < 40; i++) begin
            repeat (1 + ($urandom % 5)) step(1'b1, 1'($urandom));
            step(1'b0, 1'($urandom));
        end
        step(1'b1, 1'b0);
        covered = 0;
        for (int k = 0; k < 16; k++) covered += int'(seen[k]);
        check(covered == 16, "R3/R4/R5/R6 pair coverage", covered, 16);
        repeat (2) @(posedge clk);
        #2;
        finish_run();
    end

endmodule